// File: doc/BRIEF.md
# Stepped Power-Down Output Clock Divider

This block derives an output clock from a fast source clock. A 2-bit ratio select picks division by 1, 2, 4 or 8, and every ratio gives a 50 percent duty cycle. At ratio 1 the fast clock passes straight through. At the other ratios a half-period counter toggles a register.

A power-down request slows the output gradually. Each rising edge of a slower reference clock moves a step counter by one position. Each step adds one more factor of two to the division, up to an extra factor of 16. When the request is released, the counter walks back down, so the output returns to the programmed rate in four halvings. The step state crosses into the fast domain as a Gray code through a synchronizer. A new total ratio is applied only at the falling edge of the divided output, so the output never shows a truncated pulse.

Top module: `clkdiv_pd_ramp`

## Requirements
- R1: With power-down idle, the output period is 1, 2, 4 or 8 fast-clock periods for `div_sel` values 0, 1, 2 and 3 respectively.
- R2: In steady state at every total ratio, the output high time equals half the output period.
- R3: While `pd_req` is held, the extra division saturates at 16, so the total ratio becomes 16 times the `div_sel` ratio (at most 128).
- R4: After `pd_req` is asserted, the extra division goes through 2, 4, 8 and 16, moving one step on each rising edge of `clk_ref`, and no step is skipped.
- R5: After `pd_req` is released from full power-down, the output returns to the programmed ratio in exactly four halvings, one per `clk_ref` rising edge.
- R6: If `pd_req` is released partway through the ramp down, the step counter reverses from its current position and does not first reach divide-by-16.
- R7: A new ratio, whether from `div_sel` or from a power-down step, takes effect only at a falling edge of the output. No high or low pulse is ever shorter than half a fast-clock period.
- R8: While `rst` is high, `clk_out` is low and the power-down step is cleared. After reset the output runs at the `div_sel` ratio with no extra division.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_fast | input | 1 | Fast source clock to be divided |
| clk_ref | input | 1 | Slow reference clock that paces the power-down steps |
| rst | input | 1 | Synchronous active-high reset, held for at least one edge of each clock |
| div_sel | input | 2 | Ratio select: 0 gives /1, 1 gives /2, 2 gives /4, 3 gives /8; synchronous to `clk_fast` |
| pd_req | input | 1 | Power-down request, sampled on `clk_ref` |
| clk_out | output | 1 | Divided single-ended output clock |

## Verification
The assertions check the step counter on every reference edge: it stays in range, rises by exactly one while the request is held, falls by exactly one after release (including a reversal mid-ramp), and holds at either end. They also check on every fast edge that the active ratio changes only at a high-to-low transition of the divided register or out of bypass. The actual output waveform can only be shown by the bench scenarios. These cover the periods and high times at each ratio, the exact sequence of high times during entry, exit and reversal, and the shortest pulse seen across live changes of the ratio select.

// File: rtl/clkdiv_pd_pkg.sv
package clkdiv_pd_pkg;

  // Wide enough for any step counter this block is built with.
  localparam int GRAY_MAX_W = 8;

  function automatic logic [GRAY_MAX_W-1:0] bin_to_gray(input logic [GRAY_MAX_W-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [GRAY_MAX_W-1:0] gray_to_bin(input logic [GRAY_MAX_W-1:0] g);
    logic [GRAY_MAX_W-1:0] b;
    b[GRAY_MAX_W-1] = g[GRAY_MAX_W-1];
    for (int i = GRAY_MAX_W - 2; i >= 0; i--) begin
      b[i] = b[i+1] ^ g[i];
    end
    return b;
  endfunction

endpackage

// File: rtl/clkdiv_pd_stepper.sv
// Reference-domain step counter: 0 means no extra division,
// PD_STAGES means an extra division of 2**PD_STAGES.
module clkdiv_pd_stepper
  import clkdiv_pd_pkg::*;
#(
  parameter int PD_STAGES = 4,
  parameter int STEP_W    = 3
) (
  input  logic              clk_ref,
  input  logic              rst,
  input  logic              pd_req,
  output logic [STEP_W-1:0] step_gray_q
);

  logic [STEP_W-1:0] step_q;
  logic [STEP_W-1:0] step_nx;

  always_comb begin
    step_nx = step_q;
    if (pd_req && (step_q != STEP_W'(PD_STAGES))) begin
      step_nx = step_q + 1'b1;
    end else if (!pd_req && (step_q != '0)) begin
      step_nx = step_q - 1'b1;
    end
  end

  always_ff @(posedge clk_ref) begin
    if (rst) begin
      step_q      <= '0;
      step_gray_q <= '0;
    end else begin
      step_q      <= step_nx;
      step_gray_q <= STEP_W'(bin_to_gray(GRAY_MAX_W'(step_nx)));
    end
  end

endmodule

// File: rtl/clkdiv_gray_sync.sv
// Multi-stage synchronizer for a Gray-coded bus (one bit changes per step).
module clkdiv_gray_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stage_q [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stage_q[i] <= '0;
        else     stage_q[i] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stage_q[i] <= '0;
        else     stage_q[i] <= stage_q[i-1];
      end
    end
  end

  assign q = stage_q[STAGES-1];

endmodule

// File: rtl/clkdiv_core.sv
// Fast-domain divider. The active exponent act_e gives total ratio 2**act_e.
// act_e == 0 means bypass (ratio 1); the clock mux is in the top level.
module clkdiv_core #(
  parameter int SEL_W  = 2,
  parameter int STEP_W = 3,
  parameter int EXP_W  = 3,
  parameter int CNT_W  = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] sel,
  input  logic [STEP_W-1:0] step,
  output logic [EXP_W-1:0] act_e,
  output logic             div_q
);

  logic [EXP_W-1:0] tgt_e;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] half_m1;

  assign tgt_e = EXP_W'(sel) + EXP_W'(step);

  // Half period minus one, in fast cycles: 2**(act_e-1) - 1.
  assign half_m1 = ~({CNT_W{1'b1}} << (act_e - 1'b1));

  always_ff @(posedge clk) begin
    if (rst) begin
      act_e <= '0;
      cnt_q <= '0;
      div_q <= 1'b0;
    end else if (act_e == '0) begin
      // Bypass: leave as soon as a real division is requested.
      if (tgt_e != '0) begin
        act_e <= tgt_e;
        cnt_q <= '0;
        div_q <= 1'b0;
      end
    end else if (cnt_q == half_m1) begin
      cnt_q <= '0;
      if (div_q) begin
        // Falling edge of the output: the only point a new ratio is taken.
        div_q <= 1'b0;
        act_e <= tgt_e;
      end else begin
        div_q <= 1'b1;
      end
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/clkdiv_pd_ramp.sv
module clkdiv_pd_ramp #(
  parameter int SEL_W       = 2,
  parameter int PD_STAGES   = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_fast,
  input  logic             clk_ref,
  input  logic             rst,
  input  logic [SEL_W-1:0] div_sel,
  input  logic             pd_req,
  output logic             clk_out
);

  localparam int STEP_W  = $clog2(PD_STAGES + 1);
  localparam int MAX_EXP = (1 << SEL_W) - 1 + PD_STAGES;
  localparam int EXP_W   = $clog2(MAX_EXP + 1);
  localparam int CNT_W   = (MAX_EXP > 1) ? (MAX_EXP - 1) : 1;

  logic [STEP_W-1:0] step_gray;
  logic [STEP_W-1:0] step_gray_sync;
  logic [STEP_W-1:0] step_fast;
  logic [EXP_W-1:0]  act_e;
  logic              div_q;
  logic              bypass_q;

  clkdiv_pd_stepper #(
    .PD_STAGES(PD_STAGES),
    .STEP_W   (STEP_W)
  ) u_step (
    .clk_ref    (clk_ref),
    .rst        (rst),
    .pd_req     (pd_req),
    .step_gray_q(step_gray)
  );

  clkdiv_gray_sync #(
    .W     (STEP_W),
    .STAGES(SYNC_STAGES)
  ) u_sync (
    .clk(clk_fast),
    .rst(rst),
    .d  (step_gray),
    .q  (step_gray_sync)
  );

  assign step_fast = STEP_W'(clkdiv_pd_pkg::gray_to_bin(
                       clkdiv_pd_pkg::GRAY_MAX_W'(step_gray_sync)));

  clkdiv_core #(
    .SEL_W (SEL_W),
    .STEP_W(STEP_W),
    .EXP_W (EXP_W),
    .CNT_W (CNT_W)
  ) u_core (
    .clk  (clk_fast),
    .rst  (rst),
    .sel  (div_sel),
    .step (step_fast),
    .act_e(act_e),
    .div_q(div_q)
  );

  // The bypass select changes only while clk_fast is low, and the divided
  // register is low around every bypass change, so the mux does not glitch.
  always_ff @(negedge clk_fast) begin
    if (rst) bypass_q <= 1'b0;
    else     bypass_q <= (act_e == '0);
  end

  assign clk_out = bypass_q ? clk_fast : div_q;

endmodule

// File: rtl/clkdiv_pd_ramp_chk.sv
module clkdiv_pd_ramp_chk #(
  parameter int PD_STAGES = 4,
  parameter int STEP_W    = 3,
  parameter int EXP_W     = 3
) (
  input logic              clk_fast,
  input logic              clk_ref,
  input logic              rst,
  input logic              pd_req,
  input logic [STEP_W-1:0] step_gray,
  input logic [EXP_W-1:0]  act_e,
  input logic              div_q
);

  logic [STEP_W-1:0] step;
  assign step = STEP_W'(clkdiv_pd_pkg::gray_to_bin(
                  clkdiv_pd_pkg::GRAY_MAX_W'(step_gray)));

  // R3: the step never passes full power-down.
  p_step_bounded_r3: assert property (@(posedge clk_ref) disable iff (rst)
    step <= STEP_W'(PD_STAGES));

  // R3: held request at full power-down stays there.
  p_hold_full_r3: assert property (@(posedge clk_ref) disable iff (rst)
    (pd_req && step == STEP_W'(PD_STAGES)) |=> (step == STEP_W'(PD_STAGES)));

  // R4: one step up per reference edge while requested.
  p_entry_one_step_r4: assert property (@(posedge clk_ref) disable iff (rst)
    (pd_req && step != STEP_W'(PD_STAGES)) |=> (step == STEP_W'($past(step) + 1'b1)));

  // R5 and R6: one step down per reference edge after release, from wherever it is.
  p_exit_one_step_r6: assert property (@(posedge clk_ref) disable iff (rst)
    (!pd_req && step != '0) |=> (step == STEP_W'($past(step) - 1'b1)));

  // R5: released and at rest stays at rest.
  p_rest_stays_r5: assert property (@(posedge clk_ref) disable iff (rst)
    (!pd_req && step == '0) |=> (step == '0));

  // R7: ratio changes only at an output fall or when leaving bypass.
  p_change_at_fall_r7: assert property (@(posedge clk_fast) disable iff (rst)
    !$stable(act_e) |-> ($past(div_q) || $past(act_e) == '0));

  // R7: after any ratio change the divided register starts low.
  p_low_after_change_r7: assert property (@(posedge clk_fast) disable iff (rst)
    !$stable(act_e) |-> !div_q);

endmodule

bind clkdiv_pd_ramp clkdiv_pd_ramp_chk #(
  .PD_STAGES(PD_STAGES),
  .STEP_W   (STEP_W),
  .EXP_W    (EXP_W)
) u_chk (
  .clk_fast (clk_fast),
  .clk_ref  (clk_ref),
  .rst      (rst),
  .pd_req   (pd_req),
  .step_gray(step_gray),
  .act_e    (act_e),
  .div_q    (div_q)
);

// File: tb/clkdiv_pd_ramp_tb.sv
`timescale 1ns/1ns
module clkdiv_pd_ramp_tb;

  localparam int TCLK = 10;
  localparam int TREF = 400;

  logic       clk_fast = 1'b0;
  logic       clk_ref  = 1'b0;
  logic       rst      = 1'b1;
  logic [1:0] div_sel  = 2'd0;
  logic       pd_req   = 1'b0;
  logic       clk_out;

  int checks = 0;
  int errors = 0;

  always #(TCLK/2) clk_fast = ~clk_fast;
  initial begin
    #3;
    forever #(TREF/2) clk_ref = ~clk_ref;
  end

  clkdiv_pd_ramp u_dut (
    .clk_fast(clk_fast),
    .clk_ref (clk_ref),
    .rst     (rst),
    .div_sel (div_sel),
    .pd_req  (pd_req),
    .clk_out (clk_out)
  );

  // Output monitor: edge times in ns
  longint last_rise = -1;
  longint last_fall = -1;
  int     last_period = 0;
  int     last_high = 0;
  int     min_high = 1000000;
  int     min_low  = 1000000;
  bit     armed = 0;
  bit     log_en = 0;
  int     hlog [256];
  int     hn = 0;

  always @(posedge clk_out) begin
    if (armed && last_rise >= 0) last_period = int'($time - last_rise);
    if (armed && last_fall >= 0 && int'($time - last_fall) < min_low)
      min_low = int'($time - last_fall);
    last_rise = $time;
  end

  always @(negedge clk_out) begin
    if (armed && last_rise >= 0) begin
      last_high = int'($time - last_rise);
      if (last_high < min_high) min_high = last_high;
      if (log_en && hn < 256) begin
        hlog[hn] = last_high;
        hn++;
      end
    end
    last_fall = $time;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic measure(output int per, output int hi);
    @(posedge clk_out);
    @(posedge clk_out);
    @(posedge clk_out);
    #1;
    per = last_period;
    hi  = last_high;
  endtask

  task automatic set_sel(input logic [1:0] s);
    @(negedge clk_fast);
    div_sel = s;
  endtask

  task automatic set_pd(input logic v);
    @(negedge clk_ref);
    pd_req = v;
  endtask

  // Compare the run-length-compressed high-time log with an expected list
  task automatic check_seq(input string req, input int exp_seq [5], input int exp_n);
    int seq [16];
    int n = 0;
    for (int i = 0; i < hn; i++) begin
      if (n == 0 || seq[n-1] != hlog[i]) begin
        if (n < 16) seq[n] = hlog[i];
        n++;
      end
    end
    check(n == exp_n, {req, " step count"}, n, exp_n);
    for (int i = 0; i < exp_n && i < n && i < 16; i++) begin
      check(seq[i] == exp_seq[i], {req, " step value"}, seq[i], exp_seq[i]);
    end
  endtask

  task automatic t_reset();
    #(TCLK*40);
    check(clk_out === 1'b0, "R8 output low in reset", int'(clk_out), 0);
    @(negedge clk_fast);
    rst = 1'b0;
    armed = 1;
  endtask

  task automatic t_ratio(input logic [1:0] s);
    int per, hi;
    set_sel(s);
    #(TCLK*40);
    measure(per, hi);
    check(per == (TCLK << s), "R1 period for select", per, TCLK << s);
    check(hi * 2 == per, "R2 high is half period", hi, per / 2);
  endtask

  task automatic t_after_reset();
    int per, hi;
    #(TCLK*20);
    measure(per, hi);
    check(per == TCLK, "R8 ratio 1 right after reset", per, TCLK);
  endtask

  task automatic t_pd_full(input logic [1:0] s);
    int per, hi;
    set_sel(s);
    #(TCLK*40);
    set_pd(1'b1);
    #(TREF*8);
    measure(per, hi);
    check(per == (TCLK << s) * 16, "R3 full power-down period", per, (TCLK << s) * 16);
    check(hi * 2 == per, "R2 duty at power-down ratio", hi, per / 2);
    set_pd(1'b0);
    #(TREF*8);
    measure(per, hi);
    check(per == (TCLK << s), "R5 back to programmed period", per, TCLK << s);
  endtask

  task automatic t_entry_exit();
    int up [5]   = '{5, 10, 20, 40, 80};
    int down [5] = '{80, 40, 20, 10, 5};
    set_sel(2'd0);
    #(TCLK*40);
    hn = 0;
    log_en = 1;
    set_pd(1'b1);
    #(TREF*8);
    log_en = 0;
    check_seq("R4 entry ramp", up, 5);
    hn = 0;
    log_en = 1;
    set_pd(1'b0);
    #(TREF*8);
    log_en = 0;
    check_seq("R5 exit ramp", down, 5);
  endtask

  task automatic t_reversal();
    int seq5 [5] = '{5, 10, 20, 10, 5};
    int mx = 0;
    set_sel(2'd0);
    #(TCLK*40);
    hn = 0;
    log_en = 1;
    set_pd(1'b1);
    @(posedge clk_ref);
    @(posedge clk_ref);
    #(TCLK);
    pd_req = 1'b0;
    #(TREF*6);
    log_en = 0;
    for (int i = 0; i < hn; i++) if (hlog[i] > mx) mx = hlog[i];
    check(mx == 20, "R6 ramp reverses before divide-by-16", mx, 20);
    check_seq("R6 reversal sequence", seq5, 5);
  endtask

  task automatic t_live_select();
    int per, hi;
    min_high = 1000000;
    min_low  = 1000000;
    set_sel(2'd3);
    #(TCLK*57);
    set_sel(2'd0);
    #(TCLK*33);
    set_sel(2'd2);
    #(TCLK*7);
    set_sel(2'd1);
    #(TCLK*3);
    set_sel(2'd0);
    #(TCLK*11);
    set_sel(2'd2);
    #(TCLK*40);
    measure(per, hi);
    check(per == 4 * TCLK, "R7 settles at new ratio", per, 4 * TCLK);
    check(min_high >= TCLK / 2, "R7 no short high pulse", min_high, TCLK / 2);
    check(min_low >= TCLK / 2, "R7 no short low pulse", min_low, TCLK / 2);
  endtask

  initial begin
    #(TCLK * 190000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_after_reset();
    for (int s = 0; s < 4; s++) t_ratio(2'(s));
    t_pd_full(2'd3);
    t_pd_full(2'd1);
    t_entry_exit();
    t_reversal();
    t_live_select();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule